// File: doc/BRIEF.md
# Byte-Serial Instruction Decoder

This block sits between an instruction byte stream and an execution stage. It handles a compact 16-bit instruction set with a two-operand ALU group, a one-operand ALU group, port I/O, stack, jump, interrupt and control operations. Bytes arrive one per valid/ready handshake. The first byte is the opcode. The decoder classifies it and then, where needed, takes a mode byte that selects the addressing form. It then collects whatever trailing bytes the form needs: an address, a displacement, an immediate, a port number or an interrupt number.

Once the last byte has arrived, the decoder presents a single record on a valid/ready output. The record is held until it is accepted. While the record waits, no further input is accepted. Encodings that are not defined produce a record marked illegal. After an illegal byte the decoder goes straight back to waiting for an opcode, so it never consumes the bytes that would otherwise have followed.

Top module: `insn_decoder`

## Requirements
- R1: A synchronous reset, which may arrive in the middle of an instruction, leaves `in_ready`=1 and `out_valid`=0. The next byte accepted is then treated as an opcode.
- R2: While `out_valid`=1, `in_ready` is 0. Every record field stays constant until a cycle in which `out_ready`=1, and after that cycle `out_valid` falls.
- R3: Opcodes 0x80–0x8F set `op` = 2 + opcode[3:1] (MOV, AND, OR, XOR, ADD, ADC, SUB, SBB = 2..9). Opcodes 0xA2/0xA3 give `op`=10 (TEST) and 0xAC/0xAD give `op`=11 (CMP). For all of these, opcode bit 0 drives `wide` (1 = 16-bit).
- R4: For a two-operand opcode, the mode byte 00sssddd is register to register: `src_kind`=`dst_kind`=1, `reg_src`=sss, `reg_dst`=ddd. The mode bytes 01000ddd, 01010ddd, 01100ddd and 01001ddd load register ddd (`dst_kind`=1) from direct (2), indirect (3), indirect+offset (4) or immediate (5) sources. Kind 0 means no operand.
- R5: The mode bytes 11000sss, 11010sss and 11100sss store register sss (`src_kind`=1, `reg_src`=sss) to memory with kind 2, 3 or 4. The bytes 0xC8, 0xD8 and 0xE8 store an immediate (`src_kind`=5) to the same three kinds. A direct or offset form takes its address or displacement bytes before the two immediate bytes.
- R6: Opcodes 0x40–0x47 give `op` = 12 + opcode[2:1] (NOT, NEG, INC, DEC) and `wide` = bit 0. Their mode byte is one of four forms. 00000ddd is a register (`dst_kind`=1, `reg_dst`=ddd). 0xC0 is direct and 0xD0 is indirect. 0xE0 is offset. The direct and offset forms are followed by two bytes.
- R7: Two-byte fields arrive low byte first and are placed in `addr` or `imm`. When `wide`=0, the second immediate byte is still consumed, but `imm[15:8]` reads 0.
- R8: Opcodes 0x50–0x57 are IN (`op`=16, bit 2 = 0) or OUT (`op`=17, bit 2 = 1), with `wide` = bit 0. If bit 1 is 0, one more byte is taken as `port` with `port_var`=0. If bit 1 is 1, no byte follows and `port_var`=1.
- R9: Opcodes 0x20–0x27 give `op`=22 with `cond` = opcode[2:0]. In `cond`, bits 2:1 select the carry, zero, sign or overflow flag, and bit 0 negates the test. 0x30 gives `op`=23 and 0x31 gives `op`=24. All of these take a 2-byte `addr`. 0x33 gives `op`=25 and takes no bytes.
- R10: Several opcodes take no further byte. 0x60–0x67 give PUSH (`op`=18) and 0x68–0x6F give POP (`op`=19); both have `wide`=1 and `reg_dst`=opcode[2:0]. 0x70 gives `op`=20 and 0x78 gives `op`=21. 0x18 gives 26, 0x19 gives 27 and 0x1B gives 29. 0x10 gives 0 and 0x11 gives 1. The opcode 0x1A gives `op`=28 and takes one more byte, placed in `imm[7:0]`.
- R11: An undefined opcode produces a record right after that byte. So does an undefined mode byte, including an immediate-store form whose low three bits are not 000. That record has `op`=31, `illegal`=1 and every other field 0.
- R12: With 16-bit width, register codes 5–7 are undefined. Any instruction that names one, including PUSH and POP, gives the illegal record of R11. With 8-bit width, all eight codes are legal.
- R13: In a record that is not illegal, every field that does not apply to the instruction reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Decoder will take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| op | output | 5 | Operation code (values in requirements) |
| illegal | output | 1 | Undefined encoding seen |
| wide | output | 1 | 1 = 16-bit operands |
| src_kind | output | 3 | Source kind: 0 none, 1 reg, 2 direct, 3 indirect, 4 offset, 5 immediate |
| dst_kind | output | 3 | Destination kind, same coding |
| reg_src | output | 3 | Source register code |
| reg_dst | output | 3 | Destination register code |
| addr | output | 16 | Address, jump target or displacement |
| imm | output | 16 | Immediate or interrupt number |
| port | output | 8 | Fixed port number |
| port_var | output | 1 | Port taken from the DX register |
| cond | output | 3 | Jump condition: flag select and negate |

## Verification
Random instruction streams are drawn per opcode class. For two-operand and one-operand opcodes, mode bytes come mostly from the valid forms with random register bits, so wide/narrow register legality and byte counts vary. Fully random opcode and mode bytes add coverage of the illegal paths. In every case the number of bytes accepted before the record appears is checked against the bench model, which separates premature or late completion from wrong field routing. Directed cases then cover specific points. Store-immediate forms check the order of address versus immediate bytes. Narrow immediates check that the high byte is dropped. Wide register codes 5–7 are checked against their narrow counterparts, and a reset lands halfway through an instruction. Random input gaps and delayed acceptance of the output exercise the hold behaviour.

// File: rtl/insn_decoder.sv
module insn_decoder (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [4:0]  op,
  output logic        illegal,
  output logic        wide,
  output logic [2:0]  src_kind,
  output logic [2:0]  dst_kind,
  output logic [2:0]  reg_src,
  output logic [2:0]  reg_dst,
  output logic [15:0] addr,
  output logic [15:0] imm,
  output logic [7:0]  port,
  output logic        port_var,
  output logic [2:0]  cond
);
  localparam logic [2:0] K_NONE = 3'd0, K_REG = 3'd1, K_DIR = 3'd2,
                         K_IND = 3'd3, K_OFS = 3'd4, K_IMM = 3'd5;
  localparam logic [4:0] OP_NOP = 5'd0, OP_HLT = 5'd1, OP_MOV = 5'd2,
    OP_TEST = 5'd10, OP_CMP = 5'd11, OP_NOT = 5'd12, OP_IN = 5'd16,
    OP_OUT = 5'd17, OP_PUSH = 5'd18, OP_POP = 5'd19, OP_PUSHF = 5'd20,
    OP_POPF = 5'd21, OP_JCC = 5'd22, OP_JMP = 5'd23, OP_CALL = 5'd24,
    OP_RET = 5'd25, OP_CLI = 5'd26, OP_STI = 5'd27, OP_INT = 5'd28,
    OP_IRET = 5'd29, OP_BAD = 5'd31;

  typedef enum logic [1:0] {S_OP, S_MODE, S_TAIL, S_OUT} st_t;
  st_t st;
  logic       cls_bin, need_ad, one_byte;
  logic [1:0] idx, last;

  assign in_ready  = (st != S_OUT);
  assign out_valid = (st == S_OUT);
  wire        take = in_valid && in_ready;
  wire [7:0]  b    = in_byte;

  function automatic logic bad_reg(input logic w, input logic [2:0] c);
    return w && c[2] && (c[1:0] != 2'b00);
  endfunction

  function automatic logic [2:0] mem_kind(input logic [1:0] f);
    return (f == 2'b00) ? K_DIR : (f == 2'b01) ? K_IND : K_OFS;
  endfunction

  logic [4:0] o_op;
  logic       o_ok, o_mode, o_ad, o_b8, o_wide, o_pv;
  logic [2:0] o_rd, o_cond;

  always_comb begin
    o_op = OP_BAD; o_ok = 1'b1; o_mode = 1'b0; o_ad = 1'b0; o_b8 = 1'b0;
    o_wide = 1'b0; o_pv = 1'b0; o_rd = 3'd0; o_cond = 3'd0;
    casez (b)
      8'b1000_????: begin o_op = OP_MOV + {2'b00, b[3:1]}; o_mode = 1'b1; o_wide = b[0]; end
      8'b1010_001?: begin o_op = OP_TEST; o_mode = 1'b1; o_wide = b[0]; end
      8'b1010_110?: begin o_op = OP_CMP;  o_mode = 1'b1; o_wide = b[0]; end
      8'b0100_0???: begin o_op = OP_NOT + {3'b000, b[2:1]}; o_mode = 1'b1; o_wide = b[0]; end
      8'b0101_0???: begin
        o_op = b[2] ? OP_OUT : OP_IN; o_wide = b[0]; o_pv = b[1]; o_b8 = !b[1];
      end
      8'b0110_????: begin
        if (bad_reg(1'b1, b[2:0])) o_ok = 1'b0;
        else begin o_op = b[3] ? OP_POP : OP_PUSH; o_wide = 1'b1; o_rd = b[2:0]; end
      end
      8'h70: o_op = OP_PUSHF;
      8'h78: o_op = OP_POPF;
      8'b0010_0???: begin o_op = OP_JCC; o_cond = b[2:0]; o_ad = 1'b1; end
      8'h30: begin o_op = OP_JMP;  o_ad = 1'b1; end
      8'h31: begin o_op = OP_CALL; o_ad = 1'b1; end
      8'h33: o_op = OP_RET;
      8'h18: o_op = OP_CLI;
      8'h19: o_op = OP_STI;
      8'h1A: begin o_op = OP_INT; o_b8 = 1'b1; end
      8'h1B: o_op = OP_IRET;
      8'h10: o_op = OP_NOP;
      8'h11: o_op = OP_HLT;
      default: o_ok = 1'b0;
    endcase
  end

  logic       m_ok, m_ad, m_imm;
  logic [2:0] m_src, m_dst, m_rs, m_rd;

  always_comb begin
    m_ok = 1'b0; m_ad = 1'b0; m_imm = 1'b0;
    m_src = K_NONE; m_dst = K_NONE; m_rs = 3'd0; m_rd = 3'd0;
    if (cls_bin) begin
      case (b[7:6])
        2'b00: begin
          m_ok = !bad_reg(wide, b[5:3]) && !bad_reg(wide, b[2:0]);
          m_src = K_REG; m_dst = K_REG; m_rs = b[5:3]; m_rd = b[2:0];
        end
        2'b01: begin
          m_dst = K_REG; m_rd = b[2:0];
          if (b[3]) begin m_ok = (b[5:4] == 2'b00); m_src = K_IMM; m_imm = 1'b1; end
          else begin m_ok = (b[5:4] != 2'b11); m_src = mem_kind(b[5:4]); m_ad = (b[5:4] != 2'b01); end
          m_ok = m_ok && !bad_reg(wide, b[2:0]);
        end
        2'b11: begin
          m_dst = mem_kind(b[5:4]); m_ad = (b[5:4] != 2'b01);
          if (b[3]) begin m_ok = (b[5:4] != 2'b11) && (b[2:0] == 3'd0); m_src = K_IMM; m_imm = 1'b1; end
          else begin m_ok = (b[5:4] != 2'b11) && !bad_reg(wide, b[2:0]); m_src = K_REG; m_rs = b[2:0]; end
        end
        default: m_ok = 1'b0;
      endcase
    end else if (b[7:3] == 5'd0) begin
      m_ok = !bad_reg(wide, b[2:0]); m_dst = K_REG; m_rd = b[2:0];
    end else begin
      m_ok = (b[7:6] == 2'b11) && (b[3:0] == 4'd0) && (b[5:4] != 2'b11);
      m_dst = mem_kind(b[5:4]); m_ad = (b[5:4] != 2'b01);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_OP; cls_bin <= 1'b0; need_ad <= 1'b0; one_byte <= 1'b0;
      idx <= 2'd0; last <= 2'd0;
      op <= OP_NOP; illegal <= 1'b0; wide <= 1'b0; src_kind <= K_NONE;
      dst_kind <= K_NONE; reg_src <= 3'd0; reg_dst <= 3'd0; addr <= 16'd0;
      imm <= 16'd0; port <= 8'd0; port_var <= 1'b0; cond <= 3'd0;
    end else begin
      case (st)
        S_OP: if (take) begin
          src_kind <= K_NONE; dst_kind <= K_NONE; reg_src <= 3'd0;
          addr <= 16'd0; imm <= 16'd0; port <= 8'd0;
          op <= o_op; illegal <= !o_ok; wide <= o_wide; reg_dst <= o_rd;
          cond <= o_cond; port_var <= o_pv;
          cls_bin <= b[7]; need_ad <= o_ad; one_byte <= o_b8;
          idx <= 2'd0; last <= o_ad ? 2'd1 : 2'd0;
          if (!o_ok)                st <= S_OUT;
          else if (o_mode)          st <= S_MODE;
          else if (o_ad || o_b8)    st <= S_TAIL;
          else                      st <= S_OUT;
        end
        S_MODE: if (take) begin
          if (!m_ok) begin
            op <= OP_BAD; illegal <= 1'b1; wide <= 1'b0; reg_dst <= 3'd0;
            st <= S_OUT;
          end else begin
            src_kind <= m_src; dst_kind <= m_dst; reg_src <= m_rs; reg_dst <= m_rd;
            need_ad <= m_ad; last <= (m_ad && m_imm) ? 2'd3 : 2'd1;
            st <= (m_ad || m_imm) ? S_TAIL : S_OUT;
          end
        end
        S_TAIL: if (take) begin
          if (one_byte) begin
            if (op == OP_INT) imm[7:0] <= b;
            else              port <= b;
          end else if (need_ad && !idx[1]) begin
            if (idx[0]) addr[15:8] <= b; else addr[7:0] <= b;
          end else begin
            if (idx[0]) imm[15:8] <= wide ? b : 8'd0; else imm[7:0] <= b;
          end
          idx <= idx + 2'd1;
          if (idx == last) st <= S_OUT;
        end
        S_OUT: if (out_ready) st <= S_OP;
        default: st <= S_OP;
      endcase
    end
  end
endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [4:0]  op,
  input logic        illegal,
  input logic        wide,
  input logic [2:0]  src_kind,
  input logic [2:0]  dst_kind,
  input logic [2:0]  reg_src,
  input logic [2:0]  reg_dst,
  input logic [15:0] addr,
  input logic [15:0] imm,
  input logic [7:0]  port,
  input logic        port_var,
  input logic [2:0]  cond
);
  wire [62:0] rec = {op, illegal, wide, src_kind, dst_kind, reg_src, reg_dst,
                     addr, imm, port, port_var, cond};

  AST_NO_INPUT_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R2
  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(rec)); // R2
  AST_RECORD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid); // R2
  AST_BAD_IS_MARKED: assert property (@(posedge clk) disable iff (rst)
    out_valid && illegal |-> op == 5'd31 && src_kind == 3'd0 && dst_kind == 3'd0 && !wide); // R11
  AST_WIDE_REG_DEFINED: assert property (@(posedge clk) disable iff (rst)
    out_valid && !illegal && wide && dst_kind == 3'd1 |-> reg_dst < 3'd5); // R12
  AST_NARROW_IMM: assert property (@(posedge clk) disable iff (rst)
    out_valid && !illegal && !wide && src_kind == 3'd5 |-> imm[15:8] == 8'd0); // R7
endmodule

bind insn_decoder insn_decoder_chk chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .op(op), .illegal(illegal), .wide(wide),
  .src_kind(src_kind), .dst_kind(dst_kind), .reg_src(reg_src),
  .reg_dst(reg_dst), .addr(addr), .imm(imm), .port(port),
  .port_var(port_var), .cond(cond));

// File: tb/insn_decoder_test.sv
module insn_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = 8'd0;
  logic in_ready, out_valid, illegal, wide, port_var;
  logic [4:0] op;
  logic [2:0] src_kind, dst_kind, reg_src, reg_dst, cond;
  logic [15:0] addr, imm;
  logic [7:0] port;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_decoder uut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready), .op(op),
    .illegal(illegal), .wide(wide), .src_kind(src_kind), .dst_kind(dst_kind),
    .reg_src(reg_src), .reg_dst(reg_dst), .addr(addr), .imm(imm), .port(port),
    .port_var(port_var), .cond(cond));

  wire [62:0] got = {op, illegal, wide, src_kind, dst_kind, reg_src, reg_dst,
                     addr, imm, port, port_var, cond};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [62:0] act, input logic [62:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit badr(input logic w, input logic [2:0] c);
    return w && (c >= 3'd5);
  endfunction

  function automatic logic [62:0] model(input logic [7:0] bb [6], output int n);
    logic [4:0] o_p; logic il, w, pv, na, ni;
    logic [2:0] sk, dk, rs, rd, cd; logic [15:0] ad, im; logic [7:0] pt, o, m;
    o_p = 0; il = 0; w = 0; pv = 0; na = 0; ni = 0; sk = 0; dk = 0; rs = 0;
    rd = 0; cd = 0; ad = 0; im = 0; pt = 0;
    o = bb[0]; m = bb[1]; n = 1;
    if (o[7:4] == 4'h8 || o[7:1] == 7'b1010001 || o[7:1] == 7'b1010110) begin
      o_p = (o[7:4] == 4'h8) ? 5'(2 + o[3:1]) : (o[3] ? 5'd11 : 5'd10);
      w = o[0]; n = 2;
      case (m[7:6])
        2'd0: begin sk = 1; dk = 1; rs = m[5:3]; rd = m[2:0]; il = badr(w, rs) || badr(w, rd); end
        2'd1: begin
          dk = 1; rd = m[2:0]; il = badr(w, rd);
          case (m[5:3])
            3'd0: begin sk = 2; na = 1; end
            3'd2: sk = 3;
            3'd4: begin sk = 4; na = 1; end
            3'd1: begin sk = 5; ni = 1; end
            default: il = 1;
          endcase
        end
        2'd3: begin
          if (m[5:4] == 2'd3) il = 1;
          else begin
            dk = (m[5:4] == 0) ? 3'd2 : (m[5:4] == 1) ? 3'd3 : 3'd4;
            na = (m[5:4] != 1);
            if (m[3]) begin sk = 5; ni = 1; if (m[2:0] != 0) il = 1; end
            else begin sk = 1; rs = m[2:0]; il = badr(w, rs); end
          end
        end
        default: il = 1;
      endcase
    end else if (o[7:3] == 5'b01000) begin
      o_p = 5'(12 + o[2:1]); w = o[0]; n = 2;
      if (m[7:3] == 0) begin dk = 1; rd = m[2:0]; il = badr(w, rd); end
      else if (m == 8'hC0) begin dk = 2; na = 1; end
      else if (m == 8'hD0) dk = 3;
      else if (m == 8'hE0) begin dk = 4; na = 1; end
      else il = 1;
    end else begin
      casez (o)
        8'b0101_0???: begin o_p = o[2] ? 5'd17 : 5'd16; w = o[0]; pv = o[1];
                            if (!o[1]) begin pt = bb[1]; n = 2; end end
        8'b0110_????: begin o_p = o[3] ? 5'd19 : 5'd18; w = 1; rd = o[2:0]; il = (o[2:0] >= 5); end
        8'h70: o_p = 20;
        8'h78: o_p = 21;
        8'b0010_0???: begin o_p = 22; cd = o[2:0]; na = 1; end
        8'h30: begin o_p = 23; na = 1; end
        8'h31: begin o_p = 24; na = 1; end
        8'h33: o_p = 25;
        8'h18: o_p = 26;
        8'h19: o_p = 27;
        8'h1A: begin o_p = 28; im = {8'h00, bb[1]}; n = 2; end
        8'h1B: o_p = 29;
        8'h10: o_p = 0;
        8'h11: o_p = 1;
        default: il = 1;
      endcase
    end
    if (il) return {5'd31, 1'b1, 57'd0};
    if (na) begin ad = {bb[n+1], bb[n]}; n += 2; end
    if (ni) begin im = {w ? bb[n+1] : 8'h00, bb[n]}; n += 2; end
    return {o_p, il, w, sk, dk, rs, rd, ad, im, pt, pv, cd};
  endfunction

  task automatic do_insn(input logic [7:0] b0, b1, b2, b3, b4, b5, input string req);
    logic [7:0] bb [6];
    logic [62:0] exp, held;
    int n, k, cyc, waitc;
    bit hs, gap;
    bb = '{b0, b1, b2, b3, b4, b5};
    exp = model(bb, n);
    k = 0; cyc = 0;
    forever begin
      @(negedge clk);
      if (out_valid || cyc > 60) break;
      gap = ($urandom % 4) == 0 || k >= 6;
      in_valid = !gap;
      in_byte = (k < 6) ? bb[k] : 8'h00;
      hs = !gap && in_ready;
      @(posedge clk);
      if (hs) k++;
      cyc++;
    end
    in_valid = 1'b0;
    check(out_valid, req, "record never appeared", 63'(cyc), 63'(n));
    check(got == exp, req, "record", got, exp);
    check(k == n, req, "bytes consumed", 63'(k), 63'(n));
    held = got;
    waitc = $urandom % 3;
    for (int i = 0; i < waitc; i++) begin
      @(negedge clk);
      check(out_valid && !in_ready && got == held, "R2", "hold while not accepted",
            {out_valid, in_ready, got[60:0]}, {2'b10, held[60:0]});
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R2", "release after accept",
          63'({out_valid, in_ready}), 63'b01);
  endtask

  function automatic logic [7:0] rnd_bin_mode();
    logic [2:0] r;
    r = 3'($urandom);
    case ($urandom % 12)
      0: return {2'b00, 6'($urandom)};
      1: return {5'b01000, r};
      2: return {5'b01010, r};
      3: return {5'b01100, r};
      4: return {5'b01001, r};
      5: return {5'b11000, r};
      6: return {5'b11010, r};
      7: return {5'b11100, r};
      8: return 8'hC8;
      9: return 8'hD8;
      10: return 8'hE8;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check(in_ready && !out_valid, "R1", "state after reset", 63'({in_ready, out_valid}), 63'b10);

    for (int i = 0; i < 16; i++) begin
      do_insn(8'(8'h80 + i), 8'b00_010_011, 0, 0, 0, 0, "R3");
    end
    do_insn(8'hA3, 8'b00_000_001, 0, 0, 0, 0, "R3");
    do_insn(8'hAC, 8'b00_111_110, 0, 0, 0, 0, "R3");
    do_insn(8'h81, 8'h40, 8'h78, 8'h56, 0, 0, "R4");
    do_insn(8'h80, 8'h52, 0, 0, 0, 0, "R4");
    do_insn(8'h81, 8'h63, 8'hFE, 8'hFF, 0, 0, "R4");
    do_insn(8'h81, 8'h49, 8'h34, 8'h12, 0, 0, "R7");
    do_insn(8'h80, 8'h49, 8'h34, 8'h12, 0, 0, "R7");
    do_insn(8'h81, 8'hC8, 8'h78, 8'h56, 8'h34, 8'h12, "R5");
    do_insn(8'h80, 8'hE8, 8'hF0, 8'hFF, 8'hAA, 8'hBB, "R5");
    do_insn(8'h81, 8'hD8, 8'hEF, 8'hBE, 0, 0, "R5");
    do_insn(8'h89, 8'hD2, 0, 0, 0, 0, "R5");
    do_insn(8'h47, 8'hE0, 8'h10, 8'h20, 0, 0, "R6");
    do_insn(8'h42, 8'h07, 0, 0, 0, 0, "R6");
    do_insn(8'h81, 8'h05, 0, 0, 0, 0, "R12");
    do_insn(8'h80, 8'h3D, 0, 0, 0, 0, "R12");
    do_insn(8'h65, 0, 0, 0, 0, 0, "R12");
    do_insn(8'h41, 8'h06, 0, 0, 0, 0, "R12");
    do_insn(8'hFF, 0, 0, 0, 0, 0, "R11");
    do_insn(8'h80, 8'hA0, 0, 0, 0, 0, "R11");
    do_insn(8'h81, 8'hCA, 0, 0, 0, 0, "R11");
    do_insn(8'h50, 8'h7F, 0, 0, 0, 0, "R8");
    do_insn(8'h56, 0, 0, 0, 0, 0, "R8");
    do_insn(8'h25, 8'h00, 8'h80, 0, 0, 0, "R9");
    do_insn(8'h33, 0, 0, 0, 0, 0, "R9");
    do_insn(8'h1A, 8'h21, 0, 0, 0, 0, "R10");
    do_insn(8'h6C, 0, 0, 0, 0, 0, "R10");
    do_insn(8'h70, 0, 0, 0, 0, 0, "R13");

    @(negedge clk); in_valid = 1'b1; in_byte = 8'h81;
    @(negedge clk); in_byte = 8'hC8;
    @(negedge clk); in_byte = 8'h11;
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(in_ready && !out_valid, "R1", "reset mid-instruction", 63'({in_ready, out_valid}), 63'b10);
    do_insn(8'h10, 0, 0, 0, 0, 0, "R1");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] t0, t1;
      string req;
      t1 = 8'($urandom);
      case ($urandom % 8)
        0, 1: begin
          t0 = ($urandom % 4 == 0) ? (($urandom % 2) ? 8'hA2 : 8'hAC) | 8'($urandom % 2)
                                  : 8'h80 | 8'($urandom % 16);
          t1 = rnd_bin_mode(); req = "R4";
        end
        2: begin
          t0 = 8'h40 | 8'($urandom % 8);
          case ($urandom % 5)
            0: t1 = 8'($urandom % 8);
            1: t1 = 8'hC0;
            2: t1 = 8'hD0;
            3: t1 = 8'hE0;
            default: t1 = 8'($urandom);
          endcase
          req = "R6";
        end
        3: begin t0 = 8'h50 | 8'($urandom % 8); req = "R8"; end
        4: begin t0 = 8'h60 | 8'($urandom % 16); req = "R10"; end
        5: begin t0 = ($urandom % 2) ? 8'h20 | 8'($urandom % 8) : 8'h30 | 8'($urandom % 2); req = "R9"; end
        6: begin
          case ($urandom % 9)
            0: t0 = 8'h70; 1: t0 = 8'h78; 2: t0 = 8'h18; 3: t0 = 8'h19;
            4: t0 = 8'h1A; 5: t0 = 8'h1B; 6: t0 = 8'h10; 7: t0 = 8'h11;
            default: t0 = 8'h33;
          endcase
          req = "R10";
        end
        default: begin t0 = 8'($urandom); req = "R11"; end
      endcase
      do_insn(t0, t1, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), req);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule